// File: doc/BRIEF.md
# Compare Timer with Register Bus

A general-purpose timer that hangs off a simple register bus (address, write strobe, write data, combinational read data). An up-counter advances on ticks from one of three clock-enable inputs: a bus-rate tick, a peripheral-rate tick, or a crystal-rate tick that first passes through its own small divider. A shared 12-bit prescaler then divides the selected tick before the counter sees it. The whole design runs in one clock domain, and each clock source arrives as a single-cycle enable.

Software loads a compare value. When the counter steps onto that value, a sticky status flag is set. Software clears the flag by writing one to it. A registered interrupt line carries the flag, gated by an interrupt-enable bit. The counter never restarts on a match: it runs on and wraps through zero. A wait-state input can freeze the counter unless control allows it to keep running.

Top module: `cmp_timer`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0 and `irq` is low.
- R2: Register offsets: control 0x00 (writable bits 0, 3, 6 to 8, 9 and 10; all other bits read 0), prescaler 0x04 (bits [15:0]), status 0x08 (bit 0), interrupt enable 0x0C (bit 0), compare 0x10 (CNT_W bits), counter 0x24 (read only). Writes to the counter offset and to any unmapped offset change nothing. Unmapped offsets read 0.
- R3: While control bit 0 is clear, the counter and both prescaler stages are held at 0. Writing 0 to control therefore clears the count.
- R4: Control bits [8:6] choose the tick source: 1 selects `bus_tick`, 2 selects `per_tick`, 5 selects the crystal path. Any other value stops the counter from advancing.
- R5: The crystal path passes `xtal_tick` only while control bit 10 is set. It divides those ticks by prescaler bits [15:12] plus one before they reach the general prescaler.
- R6: With prescaler bits [11:0] = N, the counter advances once every N+1 ticks of the selected source.
- R7: While `sys_wait` is high and control bit 3 is clear, the counter and the prescalers hold their values. With bit 3 set, they keep running through the wait.
- R8: The counter wraps from all ones (2^CNT_W - 1) to 0 and is never reset by a match. Control bit 9 is stored and read back but does not change counting.
- R9: Status bit 0 is set on the clock edge at which the counter steps onto the compare value. Loading a compare value equal to a frozen count does not set it. The flag is set only once the counter wraps back to that value.
- R10: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R11: `irq` is a registered copy of (status bit 0 AND enable bit 0) and trails them by one cycle. Clearing the enable bit drops `irq` but leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe for the current offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| bus_tick | input | 1 | Bus-rate clock enable |
| per_tick | input | 1 | Peripheral-rate clock enable |
| xtal_tick | input | 1 | Crystal-rate clock enable |
| sys_wait | input | 1 | System wait-state indicator |
| irq | output | 1 | Level interrupt |

## Verification
The bench measures the count rate over windows sized to whole periods of each tick pattern. A wrong source mux, a crystal divider that ignores its enable bit, or an off-by-one in a prescaler would show up as a wrong count in such a window.

Compare detection is tested in three ways:
- with a value ahead of the count;
- with a value equal to a count frozen by the wait input, which an equality-level detector would flag at once;
- with a compare value of zero, which is reached only through a wrap, so a counter that saturates or restarts would never set the flag.

The write-one-to-clear flag is tested against a zero write, and the interrupt mask against the flag it must not clear.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int PRE_G_W = 12;
    localparam int PRE_X_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PRESC = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h24;

    localparam logic [2:0] SRC_BUS  = 3'd1;
    localparam logic [2:0] SRC_PER  = 3'd2;
    localparam logic [2:0] SRC_XTAL = 3'd5;

    typedef struct packed {
        logic       xtal_on;
        logic       free_run;
        logic [2:0] src;
        logic       wait_run;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic [PRE_X_W-1:0] xdiv;
        logic [PRE_G_W-1:0] gdiv;
    } presc_t;

    function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w      = '0;
        w[0]   = c.enable;
        w[3]   = c.wait_run;
        w[8:6] = c.src;
        w[9]   = c.free_run;
        w[10]  = c.xtal_on;
        return w;
    endfunction

endpackage

// File: rtl/timer_div.sv
module timer_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         pulse
);
    logic [W-1:0] cnt_q;

    assign pulse = step && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= pulse ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: a cleared stage stays at zero
    assert_div_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/timer_tick.sv
module timer_tick
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       wait_run,
    input  logic [2:0] src,
    input  logic       xtal_on,
    input  presc_t     presc,
    input  logic       bus_tick,
    input  logic       per_tick,
    input  logic       xtal_tick,
    input  logic       sys_wait,
    output logic       run,
    output logic       adv
);
    logic xstep;
    logic xpulse;
    logic sel_tick;
    logic gstep;

    assign run   = enable && !(sys_wait && !wait_run);
    assign xstep = run && (src == SRC_XTAL) && xtal_on && xtal_tick;

    timer_div #(.W(PRE_X_W)) u_xdiv (
        .clk   (clk),
        .rst   (rst),
        .clr   (!enable),
        .step  (xstep),
        .limit (presc.xdiv),
        .pulse (xpulse)
    );

    always_comb begin
        case (src)
            SRC_BUS:  sel_tick = bus_tick;
            SRC_PER:  sel_tick = per_tick;
            SRC_XTAL: sel_tick = xpulse;
            default:  sel_tick = 1'b0;
        endcase
    end

    assign gstep = run && sel_tick;

    timer_div #(.W(PRE_G_W)) u_gdiv (
        .clk   (clk),
        .rst   (rst),
        .clr   (!enable),
        .step  (gstep),
        .limit (presc.gdiv),
        .pulse (adv)
    );

    // R5: the crystal path yields nothing while its enable bit is clear
    assert_xtal_gate_R5: assert property (@(posedge clk) disable iff (rst)
        ((src == SRC_XTAL) && !xtal_on) |-> !adv);

    // R4: unassigned select codes never advance the counter
    assert_src_none_R4: assert property (@(posedge clk) disable iff (rst)
        ((src != SRC_BUS) && (src != SRC_PER) && (src != SRC_XTAL)) |-> !adv);

endmodule

// File: rtl/timer_core.sv
module timer_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             run,
    input  logic             adv,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = cnt + 1'b1;
    assign match    = adv && (cnt_next == cmp);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt_next;
        end
    end

    // R3: disabled module holds the count at zero
    assert_hold_off_R3: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0));

    // R7: a frozen module keeps its count
    assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && !run) |=> $stable(cnt));

    // R8: the count only steps by one (with wrap) or returns to zero
    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              match,
    output ctrl_t             ctrl,
    output presc_t            presc,
    output logic [CNT_W-1:0]  cmp,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq
);
    logic flag_q;
    logic ien_q;
    logic stat_clr;

    assign stat_clr = wr_en && (addr == OFS_STAT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            presc  <= '0;
            cmp    <= '0;
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    OFS_CTRL: ctrl <= '{xtal_on:  wr_data[10],
                                        free_run: wr_data[9],
                                        src:      wr_data[8:6],
                                        wait_run: wr_data[3],
                                        enable:   wr_data[0]};
                    OFS_PRESC: presc <= wr_data[15:0];
                    OFS_IEN:   ien_q <= wr_data[0];
                    OFS_CMP:   cmp   <= wr_data[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (match) begin
                flag_q <= 1'b1;
            end else if (stat_clr) begin
                flag_q <= 1'b0;
            end
            irq <= flag_q && ien_q;
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL:  rd_data = ctrl_pack(ctrl);
            OFS_PRESC: rd_data = BUS_W'(presc);
            OFS_STAT:  rd_data = BUS_W'(flag_q);
            OFS_IEN:   rd_data = BUS_W'(ien_q);
            OFS_CMP:   rd_data = BUS_W'(cmp);
            OFS_CNT:   rd_data = BUS_W'(cnt);
            default:   rd_data = '0;
        endcase
    end

    // R9: a match always leaves the flag set
    assert_set_R9: assert property (@(posedge clk) disable iff (rst)
        match |=> flag_q);

    // R10: a one-write clears, otherwise the flag is sticky
    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !match) |=> !flag_q);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !stat_clr) |=> flag_q);

    // R11: the interrupt trails flag AND enable by one cycle
    assert_irq_on_R11: assert property (@(posedge clk) disable iff (rst)
        (flag_q && ien_q) |=> irq);
    assert_irq_off_R11: assert property (@(posedge clk) disable iff (rst)
        !(flag_q && ien_q) |=> !irq);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       addr,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             bus_tick,
    input  logic             per_tick,
    input  logic             xtal_tick,
    input  logic             sys_wait,
    output logic             irq
);
    ctrl_t            ctrl;
    presc_t           presc;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
    logic             match;
    logic             run;
    logic             adv;

    timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cnt     (cnt),
        .match   (match),
        .ctrl    (ctrl),
        .presc   (presc),
        .cmp     (cmp),
        .rd_data (rd_data),
        .irq     (irq)
    );

    timer_tick u_tick (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.enable),
        .wait_run  (ctrl.wait_run),
        .src       (ctrl.src),
        .xtal_on   (ctrl.xtal_on),
        .presc     (presc),
        .bus_tick  (bus_tick),
        .per_tick  (per_tick),
        .xtal_tick (xtal_tick),
        .sys_wait  (sys_wait),
        .run       (run),
        .adv       (adv)
    );

    timer_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl.enable),
        .run    (run),
        .adv    (adv),
        .cmp    (cmp),
        .cnt    (cnt),
        .match  (match)
    );

endmodule

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;

    localparam int          CW   = 10;
    localparam logic [31:0] MASK = 32'h3FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        bus_tick = 1'b0;
    logic        per_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        sys_wait = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    cmp_timer #(.CNT_W(CW)) dut (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .bus_tick  (bus_tick),
        .per_tick  (per_tick),
        .xtal_tick (xtal_tick),
        .sys_wait  (sys_wait),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    // tick patterns: bus every cycle, peripheral every 3rd, crystal every 2nd
    initial begin
        forever begin
            @(negedge clk);
            #1;
            cyc = cyc + 1;
            bus_tick  = 1'b1;
            per_tick  = (cyc % 3 == 0);
            xtal_tick = (cyc % 2 == 0);
        end
    end

    // behavioural reference model
    logic [31:0] m_ctrl = '0, m_presc = '0, m_cmp = '0, m_cnt = '0;
    logic        m_ien = 1'b0, m_flag = 1'b0, m_irq = 1'b0;
    logic [3:0]  m_xd = '0;
    logic [11:0] m_gd = '0;

    always @(posedge clk) begin : model
        logic en, run, stick, adv, hit;
        logic [2:0] src;
        if (rst) begin
            m_ctrl = '0; m_presc = '0; m_cmp = '0; m_cnt = '0;
            m_ien = 1'b0; m_flag = 1'b0; m_irq = 1'b0; m_xd = '0; m_gd = '0;
        end else begin
            en    = m_ctrl[0];
            run   = en && !(sys_wait && !m_ctrl[3]);
            src   = m_ctrl[8:6];
            stick = 1'b0;
            adv   = 1'b0;
            if (run) begin
                if (src == 3'd1) stick = bus_tick;
                else if (src == 3'd2) stick = per_tick;
                else if (src == 3'd5 && m_ctrl[10] && xtal_tick) begin
                    if (m_xd == m_presc[15:12]) begin stick = 1'b1; m_xd = '0; end
                    else m_xd = m_xd + 4'd1;
                end
                if (stick) begin
                    if (m_gd == m_presc[11:0]) begin adv = 1'b1; m_gd = '0; end
                    else m_gd = m_gd + 12'd1;
                end
            end
            hit   = adv && (((m_cnt + 32'd1) & MASK) == m_cmp);
            m_irq = m_flag && m_ien;
            if (hit) m_flag = 1'b1;
            else if (wr_en && addr == 8'h08 && wr_data[0]) m_flag = 1'b0;
            if (!en) begin m_cnt = '0; m_xd = '0; m_gd = '0; end
            else if (adv) m_cnt = (m_cnt + 32'd1) & MASK;
            if (wr_en) begin
                case (addr)
                    8'h00: m_ctrl  = wr_data & 32'h7C9;
                    8'h04: m_presc = wr_data & 32'hFFFF;
                    8'h0C: m_ien   = wr_data[0];
                    8'h10: m_cmp   = wr_data & MASK;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00:   return m_ctrl;
            8'h04:   return m_presc;
            8'h08:   return {31'b0, m_flag};
            8'h0C:   return {31'b0, m_ien};
            8'h10:   return m_cmp;
            8'h24:   return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h08) return "R9";
        if (a == 8'h24) return "R8";
        return "R2";
    endfunction

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks = checks + 1;
            if (rd_data !== exp_rd(addr)) begin
                errors = errors + 1;
                $display("FAIL %s model compare at %h: actual %h expected %h",
                         tag_of(addr), addr, rd_data, exp_rd(addr));
            end
            checks = checks + 1;
            if (irq !== m_irq) begin
                errors = errors + 1;
                $display("FAIL R11 model compare irq: actual %b expected %b", irq, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        #1;
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rate(input int k, output logic [31:0] d);
        logic [31:0] c0, c1;
        peek(8'h24, c0);
        repeat (k - 1) @(negedge clk);
        peek(8'h24, c1);
        d = (c1 - c0) & MASK;
    endtask

    initial begin
        #(10 * 100000);
        errors = errors + 1;
        $display("FAIL R1 watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, c;
        repeat (5) @(negedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        peek(8'h00, v); chk("R1 ctrl", v, 0);
        peek(8'h04, v); chk("R1 presc", v, 0);
        peek(8'h08, v); chk("R1 stat", v, 0);
        peek(8'h0C, v); chk("R1 ien", v, 0);
        peek(8'h10, v); chk("R1 cmp", v, 0);
        peek(8'h24, v); chk("R1 cnt", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2: masks, read-only counter, unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF); peek(8'h00, v); chk("R2 ctrl mask", v, 32'h7C9);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF); peek(8'h04, v); chk("R2 presc mask", v, 32'hFFFF);
        wr(8'h0C, 32'hFFFF_FFFF); peek(8'h0C, v); chk("R2 ien mask", v, 32'h1);
        wr(8'h10, 32'hFFFF_FFFF); peek(8'h10, v); chk("R2 cmp width", v, MASK);
        wr(8'h40, 32'h1234);      peek(8'h40, v); chk("R2 unmapped read", v, 0);
        wr(8'h24, 32'h55);        peek(8'h24, v); chk("R2 cnt read only", v, 0);
        wr(8'h18, 32'h0);         peek(8'h10, v); chk("R2 unmapped write", v, MASK);
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'h0);

        // R4: source selection
        wr(8'h00, 32'h41); rate(20, v); chk("R4 bus source", v, 20);
        wr(8'h00, 32'h81); rate(30, v); chk("R4 peripheral source", v, 10);
        wr(8'h00, 32'hC1); rate(20, v); chk("R4 unassigned source", v, 0);

        // R5: crystal path
        wr(8'h00, 32'h141); rate(20, v); chk("R5 crystal path off", v, 0);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h7000);
        wr(8'h00, 32'h541); rate(160, v); chk("R5 crystal divide by 8", v, 10);

        // R3: disable clears and holds
        wr(8'h00, 32'h0); peek(8'h24, v); chk("R3 cleared", v, 0);
        repeat (10) @(negedge clk);
        peek(8'h24, v); chk("R3 held", v, 0);

        // R6: general prescaler
        wr(8'h04, 32'h3);
        wr(8'h00, 32'h41); rate(40, v); chk("R6 divide by 4", v, 10);

        // R7: wait mode
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h41);
        sys_wait = 1'b1;
        rate(20, v); chk("R7 frozen in wait", v, 0);
        wr(8'h00, 32'h49); rate(20, v); chk("R7 runs in wait", v, 20);
        sys_wait = 1'b0;

        // R9: compare ahead of the count
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h1);
        wr(8'h10, 32'd20);
        wr(8'h00, 32'h41);
        peek(8'h08, v); chk("R9 not yet", v, 0);
        repeat (25) @(negedge clk);
        peek(8'h08, v); chk("R9 flag set", v, 1);
        chk("R11 masked irq", {31'b0, irq}, 0);

        // R10: write-one-to-clear
        wr(8'h08, 32'h0); peek(8'h08, v); chk("R10 zero write", v, 1);
        wr(8'h08, 32'h1); peek(8'h08, v); chk("R10 one write", v, 0);

        // R9: compare equal to a frozen count
        sys_wait = 1'b1;
        wr(8'h00, 32'h41);
        peek(8'h24, c);
        wr(8'h10, c);
        repeat (5) @(negedge clk);
        peek(8'h08, v); chk("R9 equal write no flag", v, 0);
        sys_wait = 1'b0;
        repeat (1030) @(negedge clk);
        peek(8'h08, v); chk("R9 flag after wrap", v, 1);

        // R11: interrupt enable and mask
        wr(8'h0C, 32'h1);
        peek(8'h08, v);
        chk("R11 irq raised", {31'b0, irq}, 1);
        wr(8'h0C, 32'h0);
        peek(8'h08, v);
        chk("R11 irq masked", {31'b0, irq}, 0);
        chk("R11 flag kept", v, 1);

        // R8: wrap through zero, free-run bit has no effect
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h1);
        wr(8'h10, 32'h0);
        wr(8'h00, 32'h241);
        repeat (999) @(negedge clk);
        peek(8'h24, v); chk("R8 count before wrap", v, 1000);
        peek(8'h08, v); chk("R8 no flag before wrap", v, 0);
        repeat (30) @(negedge clk);
        peek(8'h24, v); chk("R8 count after wrap", v, 8);
        peek(8'h08, v); chk("R8 flag at zero", v, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule